// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two up-counters, each made of a high byte and a low byte. A counter advances on a machine-cycle tick, which is the clock divided by `TICK_DIV` (12 by default), or on falling edges of its own count pin. Edges are found by sampling the pin once per tick, so at most one edge is counted per machine cycle. A run bit enables counting. A gate bit can also make counting depend on a gate pin.

Each counter has four modes:
- a 13-bit count: a 5-bit prescaler in the low byte feeds the high byte;
- a full 16-bit count;
- an 8-bit count in the low byte that reloads from the high byte;
- a special mode. In this mode counter 1 freezes and counter 0 splits into two independent 8-bit counters.

Each counter has a sticky overflow flag. The flags are driven out directly for an interrupt controller to use. They are cleared either by software or by a per-flag acknowledge strobe.

Software reaches a mode byte, a control byte and the four count bytes through a single-cycle write port and a combinational read port.

Top module: `tc_pair`

## Requirements
- R1: While `rst_n` is low, and after it is released, every readable byte is 00h and both flags are 0. This holds until a write or a count changes it.
- R2: In tick mode (select bit 0), an enabled counter advances by exactly one on each machine cycle. A machine cycle is one pulse every `TICK_DIV` clocks; the first pulse comes `TICK_DIV` clocks after reset is released.
- R3: A counter advances only when its run bit is 1 and either its gate bit is 0 or its gate pin is 1. Both the bits and the pin are taken at the tick.
- R4: In pin mode (select bit 1), the count pin is sampled at every tick. The counter advances by one at a tick whose sample is 0 when the previous tick's sample was 1.
- R5: Mode 00: the low 5 bits of the low byte form a prescaler that carries into the high byte. Bits 7:5 of the low byte keep their written value. The flag is set when the high byte wraps from FFh to 00h.
- R6: Mode 01: the high and low bytes form one 16-bit count. The flag is set on the wrap from FFFFh to 0000h.
- R7: Mode 10: only the low byte counts. On an advance from FFh, the low byte loads the high byte's value and the flag is set.
- R8: Mode 11 on counter 1: its count bytes do not change except by a write.
- R9: Mode 11 on counter 0:
  - The low byte is an 8-bit counter. It uses run bit 0, gate bit 0, select bit 0 and flag 0.
  - The high byte counts ticks whenever run bit 1 is 1, ignoring the gate and pins, and sets flag 1 on its wrap.
  - Counter 1's overflows do not set flag 1.
- R10: Each flag stays set until it is cleared, either by writing 0 to its bit or by a pulse on its `flag_ack` bit. A hardware set in the same cycle wins over either clear, and an acknowledge wins over a write.
- R11: A write to a count byte replaces that byte at the clock edge, even if the counter would have advanced in the same cycle.
- R12: Register map, as read addresses:
  - Address 0 is the mode byte. Counter n uses nibble n: bits [1:0] are the mode, bit 2 is select (1 = pin), bit 3 is gate.
  - Address 1 is control: bit 0 is run0, bit 1 is run1, bit 4 is flag0, bit 5 is flag1, and the other bits read 0.
  - Addresses 2 and 3 are counter 0 low and high; addresses 4 and 5 are counter 1 low and high.
  - Addresses 6 and 7 read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Register address for a write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register address for a read |
| rd_data | output | 8 | Read data (combinational from `rd_addr`) |
| gate_pin | input | 2 | Per-counter gate inputs |
| cnt_pin | input | 2 | Per-counter external count inputs |
| flag_ack | input | 2 | Per-flag clear strobes |
| flag | output | 2 | Overflow flags |

## Verification
Every count and flag change becomes visible on `rd_data` and `flag` at the clock edge that carries the tick, with no extra stage. A write also lands at its own edge. A run-bit or mode change takes effect from the next tick. A count-pin edge is counted at the first tick that samples the low level.

The bench model steps once per rising edge, using the inputs that were held across that edge, and compares 1 ns later. All inputs are driven on the falling edge, so every comparison sees the settled result of exactly one edge. The read address walks through all eight addresses, which covers every byte, including the unmapped addresses, under every stimulus phase.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    TM_13B    = 2'b00,
    TM_16B    = 2'b01,
    TM_RELOAD = 2'b10,
    TM_SPLIT  = 2'b11
  } tc_mode_e;

  localparam int AW = 3;
  localparam logic [AW-1:0] A_MODE = 3'd0;
  localparam logic [AW-1:0] A_CTRL = 3'd1;
  localparam logic [AW-1:0] A_C0L  = 3'd2;
  localparam logic [AW-1:0] A_C0H  = 3'd3;
  localparam logic [AW-1:0] A_C1L  = 3'd4;
  localparam logic [AW-1:0] A_C1H  = 3'd5;
endpackage

// File: rtl/tc_tick.sv
module tc_tick #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == W'(DIV - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a machine-cycle pulse lasts one clock
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tc_source.sv
module tc_source (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic gate,
  input  logic ext_sel,
  input  logic gate_pin,
  input  logic cnt_pin,
  output logic evt
);
  logic samp_q, samp_d;
  logic fall, allowed;

  always_comb begin
    samp_d  = tick ? cnt_pin : samp_q;
    fall    = samp_q & ~cnt_pin;
    allowed = run & (~gate | gate_pin);
    evt     = tick & allowed & (ext_sel ? fall : 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= 1'b0;
    else        samp_q <= samp_d;
  end
endmodule

// File: rtl/tc_core.sv
module tc_core
  import tc_pkg::*;
#(
  parameter bit SPLIT = 1'b0,
  parameter int W     = 8,
  parameter int PRE_W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tc_mode_e     mode,
  input  logic         inc,
  input  logic         hi_inc,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic         ovf,
  output logic         hi_ovf
);
  localparam logic [W-1:0]     ALL1   = {W{1'b1}};
  localparam logic [PRE_W-1:0] PRE_MX = {PRE_W{1'b1}};

  logic [W-1:0]   lo_d, hi_d;
  logic [2*W-1:0] wide_inc;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf      = 1'b0;
    hi_ovf   = 1'b0;
    wide_inc = {hi_q, lo_q} + 1'b1;
    case (mode)
      TM_13B: begin
        if (inc) begin
          if (lo_q[PRE_W-1:0] == PRE_MX) begin
            lo_d[PRE_W-1:0] = '0;
            hi_d            = hi_q + 1'b1;
            ovf             = (hi_q == ALL1);
          end else begin
            lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
          end
        end
      end
      TM_16B: begin
        if (inc) begin
          {hi_d, lo_d} = wide_inc;
          ovf          = (lo_q == ALL1) && (hi_q == ALL1);
        end
      end
      TM_RELOAD: begin
        if (inc) begin
          if (lo_q == ALL1) begin
            lo_d = hi_q;
            ovf  = 1'b1;
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
      end
      default: begin
        if (SPLIT) begin
          if (inc) begin
            lo_d = lo_q + 1'b1;
            ovf  = (lo_q == ALL1);
          end
          if (hi_inc) begin
            hi_d   = hi_q + 1'b1;
            hi_ovf = (hi_q == ALL1);
          end
        end
      end
    endcase
    if (wr_lo) lo_d = wr_data;
    if (wr_hi) hi_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // R5: upper low-byte bits are untouched by the 13-bit count
  assert_keep_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_13B && !wr_lo) |=> (lo_q[W-1:PRE_W] == $past(lo_q[W-1:PRE_W])));

  // R6: 16-bit wrap lands on zero
  assert_wrap16_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_16B && inc && lo_q == ALL1 && hi_q == ALL1 && !wr_lo && !wr_hi)
      |=> (lo_q == '0 && hi_q == '0));

  // R7: reload takes the high byte
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_RELOAD && inc && lo_q == ALL1 && !wr_lo && !wr_hi)
      |=> (lo_q == $past(hi_q)));

  generate
    if (!SPLIT) begin : g_hold_chk
      // R8: counter 1 freezes in mode 11
      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
    end
  endgenerate
endmodule

// File: rtl/tc_pair.sv
module tc_pair
  import tc_pkg::*;
#(
  parameter int TICK_DIV = 12,
  parameter int DW       = 8,
  parameter int NCNT     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [2:0]    rd_addr,
  output logic [7:0]    rd_data,
  input  logic [1:0]    gate_pin,
  input  logic [1:0]    cnt_pin,
  input  logic [1:0]    flag_ack,
  output logic [1:0]    flag
);
  localparam int FLD = 4;

  logic            tick;
  logic [7:0]      mode_q, mode_d;
  logic [NCNT-1:0] run_q, run_d, flag_q, flag_d, flag_set;
  logic [NCNT-1:0] evt, ovf_v, hiovf_v, wr_lo, wr_hi;
  logic [DW-1:0]   lo_v [NCNT];
  logic [DW-1:0]   hi_v [NCNT];
  logic            split0;
  logic            wr_mode, wr_ctrl;

  tc_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  assign split0  = (tc_mode_e'(mode_q[1:0]) == TM_SPLIT);
  assign wr_mode = wr_en && (wr_addr == A_MODE);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

  generate
    for (genvar n = 0; n < NCNT; n++) begin : g_cnt
      logic hi_tick;
      assign wr_lo[n] = wr_en && (wr_addr == A_C0L + 3'(2 * n));
      assign wr_hi[n] = wr_en && (wr_addr == A_C0H + 3'(2 * n));
      assign hi_tick  = (n == 0) ? (tick & run_q[NCNT-1]) : 1'b0;

      tc_source u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (run_q[n]),
        .gate    (mode_q[FLD*n+3]),
        .ext_sel (mode_q[FLD*n+2]),
        .gate_pin(gate_pin[n]),
        .cnt_pin (cnt_pin[n]),
        .evt     (evt[n])
      );

      tc_core #(.SPLIT(n == 0), .W(DW)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (tc_mode_e'(mode_q[FLD*n +: 2])),
        .inc    (evt[n]),
        .hi_inc (hi_tick),
        .wr_lo  (wr_lo[n]),
        .wr_hi  (wr_hi[n]),
        .wr_data(wr_data[DW-1:0]),
        .lo_q   (lo_v[n]),
        .hi_q   (hi_v[n]),
        .ovf    (ovf_v[n]),
        .hi_ovf (hiovf_v[n])
      );
    end
  endgenerate

  always_comb begin
    flag_set[0] = ovf_v[0];
    flag_set[1] = split0 ? hiovf_v[0] : (ovf_v[1] | hiovf_v[1]);
  end

  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    flag_d = flag_q;
    if (wr_mode) mode_d = wr_data;
    if (wr_ctrl) begin
      run_d  = wr_data[1:0];
      flag_d = wr_data[5:4];
    end
    flag_d = (flag_d & ~flag_ack) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = mode_q;
      A_CTRL:  rd_data = {2'b00, flag_q, 2'b00, run_q};
      A_C0L:   rd_data = lo_v[0];
      A_C0H:   rd_data = hi_v[0];
      A_C1L:   rd_data = lo_v[1];
      A_C1H:   rd_data = hi_v[1];
      default: rd_data = 8'h00;
    endcase
  end

  assign flag = flag_q;

  generate
    for (genvar n = 0; n < NCNT; n++) begin : g_flag_chk
      // R10: a flag only rises from an overflow or a control write
      assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[n] && !$past(flag_q[n])) |-> $past(flag_set[n] || wr_ctrl));
    end
  endgenerate
endmodule

// File: tb/tc_pair_bench.sv
module tc_pair_bench;
  localparam int DIV = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [1:0] gate_pin, cnt_pin, flag_ack, flag;

  always #5 clk = ~clk;

  tc_pair #(.TICK_DIV(DIV)) u_tc_pair (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .gate_pin(gate_pin), .cnt_pin(cnt_pin),
    .flag_ack(flag_ack), .flag(flag)
  );

  int    vectors = 0;
  int    fails   = 0;
  string req     = "R1";
  bit    done    = 0;

  // behavioural reference state
  int m_pre, m_mode, m_run, m_flag;
  int m_lo[2], m_hi[2], m_smp[2];

  // stimulus knobs
  bit rnd_cnt = 0, rnd_gate = 0, rnd_ack = 0;
  int hold = 1;

  function automatic int fld(int n, int b);
    return (m_mode >> (4 * n + b)) & 1;
  endfunction

  function automatic int exp_rd(int a);
    case (a)
      0: return m_mode;
      1: return (m_flag << 4) | m_run;
      2: return m_lo[0];
      3: return m_hi[0];
      4: return m_lo[1];
      5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_pre = 0; m_mode = 0; m_run = 0; m_flag = 0;
    for (int n = 0; n < 2; n++) begin m_lo[n] = 0; m_hi[n] = 0; m_smp[n] = 0; end
  endtask

  task automatic model_step();
    int tick, split, md, v;
    int ev[2];
    int setf[2];
    int sethi;
    tick = (m_pre == DIV - 1);
    m_pre = tick ? 0 : m_pre + 1;
    for (int n = 0; n < 2; n++) begin
      int en;
      en = ((m_run >> n) & 1) && (!fld(n, 3) || gate_pin[n]);
      ev[n] = tick && en && (fld(n, 2) ? (m_smp[n] && !cnt_pin[n]) : 1);
      if (tick) m_smp[n] = cnt_pin[n];
      setf[n] = 0;
    end
    sethi = 0;
    split = ((m_mode & 3) == 3);
    for (int n = 0; n < 2; n++) begin
      md = (m_mode >> (4 * n)) & 3;
      case (md)
        0: if (ev[n]) begin
             if ((m_lo[n] & 31) == 31) begin
               m_lo[n] = m_lo[n] & 224;
               if (m_hi[n] == 255) setf[n] = 1;
               m_hi[n] = (m_hi[n] + 1) & 255;
             end else m_lo[n] = m_lo[n] + 1;
           end
        1: if (ev[n]) begin
             v = m_hi[n] * 256 + m_lo[n] + 1;
             if (v == 65536) begin setf[n] = 1; v = 0; end
             m_hi[n] = v / 256; m_lo[n] = v % 256;
           end
        2: if (ev[n]) begin
             if (m_lo[n] == 255) begin m_lo[n] = m_hi[n]; setf[n] = 1; end
             else m_lo[n] = m_lo[n] + 1;
           end
        default: if (n == 0) begin
             if (ev[0]) begin
               if (m_lo[0] == 255) setf[0] = 1;
               m_lo[0] = (m_lo[0] + 1) & 255;
             end
             if (tick && ((m_run >> 1) & 1)) begin
               if (m_hi[0] == 255) sethi = 1;
               m_hi[0] = (m_hi[0] + 1) & 255;
             end
           end
      endcase
    end
    if (split) setf[1] = sethi;
    if (wr_en) begin
      case (wr_addr)
        3'd0: m_mode = wr_data;
        3'd1: begin m_run = wr_data & 3; m_flag = (wr_data >> 4) & 3; end
        3'd2: m_lo[0] = wr_data;
        3'd3: m_hi[0] = wr_data;
        3'd4: m_lo[1] = wr_data;
        3'd5: m_hi[1] = wr_data;
        default: ;
      endcase
    end
    m_flag = (m_flag & ~int'(flag_ack)) | (setf[1] << 1) | setf[0];
  endtask

  always begin
    @(posedge clk);
    #1;
    if (!rst_n) model_reset();
    else        model_step();
    vectors++;
    if (rd_data !== 8'(exp_rd(rd_addr))) begin
      fails++;
      $display("FAIL %s: rd_data addr %0d actual %h expected %h", req, rd_addr, rd_data, 8'(exp_rd(rd_addr)));
    end
    vectors++;
    if (flag !== 2'(m_flag)) begin
      fails++;
      $display("FAIL %s: flag actual %b expected %b", req, flag, 2'(m_flag));
    end
  end

  always @(negedge clk) rd_addr <= rd_addr + 3'd1;

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rnd_cnt && ($urandom % hold) == 0) cnt_pin = 2'($urandom);
      if (rnd_gate && ($urandom % 7) == 0) gate_pin = 2'($urandom);
      flag_ack = (rnd_ack && ($urandom % 40) == 0) ? 2'($urandom) : 2'b00;
    end
    @(negedge clk);
    flag_ack = 2'b00;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    gate_pin = 2'b00; cnt_pin = 2'b00; flag_ack = 2'b00;
    // R1: reset values, then idle reads of all eight addresses (R12)
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run_cycles(20);

    // R2 / R6 / R12: tick counting in 16-bit mode, both counters wrap
    req = "R6";
    wr(3'd0, 8'h11);
    wr(3'd2, 8'hF0); wr(3'd3, 8'hFF);
    wr(3'd4, 8'h00); wr(3'd5, 8'hFF);
    req = "R2";
    wr(3'd1, 8'h03);
    run_cycles(3500);

    // R3: gated run with a toggling gate pin
    req = "R3";
    wr(3'd0, 8'h99);
    rnd_gate = 1;
    run_cycles(1500);
    wr(3'd1, 8'h01);
    run_cycles(300);
    wr(3'd1, 8'h03);
    rnd_gate = 0;

    // R4: pin counting, fast and slow pin changes, plus gating
    req = "R4";
    wr(3'd0, 8'h15);
    rnd_cnt = 1; hold = 1;
    run_cycles(1500);
    hold = 20;
    run_cycles(2000);
    wr(3'd0, 8'hD5);
    rnd_gate = 1;
    run_cycles(1000);
    rnd_gate = 0;

    // R5: 13-bit mode with upper low-byte bits set
    req = "R5";
    wr(3'd0, 8'h40);
    wr(3'd2, 8'hFC); wr(3'd3, 8'hFF);
    wr(3'd4, 8'hBE); wr(3'd5, 8'hFF);
    hold = 2;
    run_cycles(1500);

    // R7 / R10: auto-reload with frequent flags and random acknowledges
    req = "R7";
    wr(3'd0, 8'h62);
    wr(3'd3, 8'hF8); wr(3'd5, 8'hFD);
    wr(3'd1, 8'h03);
    run_cycles(1500);
    req = "R10";
    rnd_ack = 1;
    run_cycles(2000);
    wr(3'd1, 8'h33);
    run_cycles(30);
    wr(3'd1, 8'h03);
    run_cycles(30);
    rnd_ack = 0;

    // R8: counter 1 frozen in mode 11
    req = "R8";
    wr(3'd0, 8'h32);
    wr(3'd4, 8'h12);
    run_cycles(600);

    // R9: split counter 0, counter 1 reloading without flag access
    req = "R9";
    wr(3'd0, 8'h2F);
    wr(3'd3, 8'hF0); wr(3'd5, 8'hFE);
    rnd_gate = 1; hold = 3;
    run_cycles(2000);
    wr(3'd1, 8'h01);
    run_cycles(500);
    wr(3'd0, 8'h23);
    wr(3'd1, 8'h03);
    run_cycles(1000);
    rnd_gate = 0; rnd_cnt = 0;

    // R11: writes to count bytes racing the tick, in several modes
    req = "R11";
    for (int k = 0; k < 4; k++) begin
      wr(3'd0, 8'(k * 8'h11));
      for (int j = 0; j < 60; j++) begin
        wr(3'(2 + ($urandom % 4)), 8'($urandom));
        run_cycles($urandom % 5);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule